// File: doc/BRIEF.md
# Cross-Domain Match Timer

A 32-bit timer peripheral on a simple write-strobe register bus. The counter runs in its own timer clock domain, counting up once per timer clock when enabled and wrapping from all-ones to zero. A compare register raises a sticky event flag when the running count reaches it, and an enable mask turns the event flags into a level interrupt.

The bus never touches the counter directly. Loading the counter, loading the compare value and capturing the count for reading are each a request that crosses to the timer domain and returns an acknowledge. A busy bit for each kind of transfer is visible in an access-status register. Software writes the request, polls its busy bit until it drops, and only then reads the captured count or issues the next transfer of that kind.

Register offsets (byte addresses): compare 0x00, count 0x10, event status 0x14, interrupt mask 0x1C, control 0x20, access status 0x24. Unmapped offsets read zero.

Top module: `xdom_match_timer`

## Requirements
- R1: After reset the compare register reads 0xFFFFFFFF, the count register, status, mask, control and access-status registers read 0, and irq_o is low.
- R2: With control bit 0 set the counter advances by one per timer clock and wraps from 0xFFFFFFFF to 0; with bit 0 clear it holds its value.
- R3: Writing control with bit 1 set requests a capture: access-status bit 5 is high from the next bus cycle until the captured value has been copied to the count register (offset 0x10), which then returns the counter value at capture. Control bit 1 always reads 0; control bit 0 reads back as written.
- R4: Writing offset 0x10 loads the counter with the written value; access-status bit 4 is high from the next bus cycle until the load has been applied and acknowledged.
- R5: Writing offset 0x00 sets a new compare value, which reads back at once; access-status bit 0 is high from the next bus cycle until the value has reached the timer domain.
- R6: A write to 0x00 while bit 0 is high, a write to 0x10 while bit 4 is high, and a capture request while bit 5 is high are discarded.
- R7: While counting, the counter equalling the compare value sets status bit 0, which stays set until cleared; status bits 3:1 read 0.
- R8: Writing status clears each bit written as 1 and leaves bits written as 0; a new event in the same cycle wins over the clear.
- R9: irq_o is high exactly when some status bit and the same mask bit (offset 0x1C, bits 3:0) are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| tmr_clk_i | input | 1 | Timer clock, asynchronous to clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_i | input | 1 | Write strobe, one bus cycle per write |
| addr_i | input | 6 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit counter and two-stage synchronizers, with a timer clock slower than and unrelated to the bus clock so every handshake spans several bus cycles. Loading the counter through the count register makes the wrap at all-ones and a compare hit reachable in a few dozen timer cycles. The back-to-back write cases depend on the two-stage round trip being longer than one bus cycle, which holds for any synchronizer depth of two or more.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_MATCH = 'h00;
  localparam int unsigned OFF_COUNT = 'h10;
  localparam int unsigned OFF_STAT  = 'h14;
  localparam int unsigned OFF_IEN   = 'h1C;
  localparam int unsigned OFF_CTRL  = 'h20;
  localparam int unsigned OFF_ACC   = 'h24;

  localparam int unsigned EVT_N = 4;

  // access-status bit positions
  localparam int unsigned ACC_MW = 0;
  localparam int unsigned ACC_CW = 4;
  localparam int unsigned ACC_RD = 5;

  // handshake channel indices
  localparam int unsigned XF_N  = 3;
  localparam int unsigned XF_MW = 0;
  localparam int unsigned XF_CW = 1;
  localparam int unsigned XF_RD = 2;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tmr_xfer.sv
// Toggle request/acknowledge across clk domains: one transfer in flight.
module tmr_xfer #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic bclk_i,
  input  logic tclk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic strobe_o
);
  logic req_q, ack_q, req_s, ack_s, ack_d;

  always_ff @(posedge bclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ack_d <= 1'b0;
    end else begin
      if (start_i && !busy_o) req_q <= ~req_q;
      ack_d <= ack_s;
    end
  end

  tmr_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i(tclk_i), .rst_ni(rst_ni), .d_i(req_q), .q_o(req_s));

  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req_s;
  end

  assign strobe_o = req_s ^ ack_q;

  tmr_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk_i(bclk_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_s));

  assign busy_o = req_q ^ ack_s;
  assign done_o = ack_s ^ ack_d;

  // R3 R4 R5: accepted request raises busy on the next bus cycle
  assert_start_sets_busy_R5: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  // R6: completion only when nothing is outstanding
  assert_done_idle_R6: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // strobe lasts one timer cycle
  assert_strobe_single_R4: assert property (@(posedge tclk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/tmr_core.sv
// Timer-domain counter, compare and capture.
module tmr_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         mset_i,
  input  logic [W-1:0] match_val_i,
  input  logic         cap_i,
  output logic [W-1:0] snap_o,
  output logic         evt_tgl_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, match_q;
  logic         hit;

  assign hit = en_i && (cnt_q == match_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      match_q   <= '1;
      snap_o    <= '0;
      evt_tgl_o <= 1'b0;
    end else begin
      if (load_i)    cnt_q   <= load_val_i;
      else if (en_i) cnt_q   <= cnt_q + ONE;
      if (mset_i)    match_q <= match_val_i;
      if (cap_i)     snap_o  <= cnt_q;
      if (hit)       evt_tgl_o <= ~evt_tgl_o;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !load_i |=> cnt_q == $past(cnt_q) + ONE);
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_i |=> $stable(cnt_q));
  assert_count_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> snap_o == $past(cnt_q));
endmodule

// File: rtl/xdom_match_timer.sv
module xdom_match_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              tmr_clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] match_sh, cload_sh, cnt_rd;
  logic              ctrl_en;
  logic [EVT_N-1:0]  ien, stat, stat_clr, stat_set;

  logic [XF_N-1:0] xf_start, xf_busy, xf_done, xf_strobe;
  logic            hit_match, hit_count, hit_stat, hit_ien, hit_ctrl;

  logic [DATA_W-1:0] snap;
  logic              evt_tgl, evt_s, evt_d, en_t;

  assign hit_match = wr_i && (addr_i == ADDR_W'(OFF_MATCH));
  assign hit_count = wr_i && (addr_i == ADDR_W'(OFF_COUNT));
  assign hit_stat  = wr_i && (addr_i == ADDR_W'(OFF_STAT));
  assign hit_ien   = wr_i && (addr_i == ADDR_W'(OFF_IEN));
  assign hit_ctrl  = wr_i && (addr_i == ADDR_W'(OFF_CTRL));

  // requests are only accepted by the channel when idle
  assign xf_start[XF_MW] = hit_match;
  assign xf_start[XF_CW] = hit_count;
  assign xf_start[XF_RD] = hit_ctrl && wdata_i[1];

  for (genvar g = 0; g < XF_N; g++) begin : g_xf
    tmr_xfer #(.SYNC_STAGES(SYNC_STAGES)) i_xfer (
      .bclk_i  (clk_i),
      .tclk_i  (tmr_clk_i),
      .rst_ni  (rst_ni),
      .start_i (xf_start[g]),
      .busy_o  (xf_busy[g]),
      .done_o  (xf_done[g]),
      .strobe_o(xf_strobe[g])
    );
  end

  tmr_sync #(.STAGES(SYNC_STAGES)) i_en_sync (
    .clk_i(tmr_clk_i), .rst_ni(rst_ni), .d_i(ctrl_en), .q_o(en_t));

  // shadow registers stay stable while their channel is busy
  tmr_core #(.W(DATA_W)) i_core (
    .clk_i      (tmr_clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_t),
    .load_i     (xf_strobe[XF_CW]),
    .load_val_i (cload_sh),
    .mset_i     (xf_strobe[XF_MW]),
    .match_val_i(match_sh),
    .cap_i      (xf_strobe[XF_RD]),
    .snap_o     (snap),
    .evt_tgl_o  (evt_tgl)
  );

  tmr_sync #(.STAGES(SYNC_STAGES)) i_evt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_tgl), .q_o(evt_s));

  assign stat_set = EVT_N'(evt_s ^ evt_d);
  assign stat_clr = hit_stat ? wdata_i[EVT_N-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_sh <= '1;
      cload_sh <= '0;
      cnt_rd   <= '0;
      ctrl_en  <= 1'b0;
      ien      <= '0;
      stat     <= '0;
      evt_d    <= 1'b0;
    end else begin
      evt_d <= evt_s;
      if (hit_match && !xf_busy[XF_MW]) match_sh <= wdata_i;
      if (hit_count && !xf_busy[XF_CW]) cload_sh <= wdata_i;
      if (hit_ctrl) ctrl_en <= wdata_i[0];
      if (hit_ien)  ien     <= wdata_i[EVT_N-1:0];
      if (xf_done[XF_RD]) cnt_rd <= snap;
      stat <= (stat & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFF_MATCH): rdata_o = match_sh;
      ADDR_W'(OFF_COUNT): rdata_o = cnt_rd;
      ADDR_W'(OFF_STAT):  rdata_o = DATA_W'(stat);
      ADDR_W'(OFF_IEN):   rdata_o = DATA_W'(ien);
      ADDR_W'(OFF_CTRL):  rdata_o = DATA_W'(ctrl_en);
      ADDR_W'(OFF_ACC): begin
        rdata_o[ACC_MW] = xf_busy[XF_MW];
        rdata_o[ACC_CW] = xf_busy[XF_CW];
        rdata_o[ACC_RD] = xf_busy[XF_RD];
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat & ien);

  assert_stat_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat[0] && !(hit_stat && wdata_i[0]) |=> stat[0]);
  assert_stat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_stat && wdata_i[0] && !(evt_s ^ evt_d) |=> !stat[0]);
  assert_match_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_match && xf_busy[XF_MW] |=> $stable(match_sh));
  assert_count_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_count && xf_busy[XF_CW] |=> $stable(cload_sh));
  assert_irq_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien == '0 |-> !irq_o);
endmodule

// File: tb/test_xdom_match_timer.sv
module test_xdom_match_timer;
  logic        clk = 0, tclk = 0, rst_n = 0;
  logic        wr = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          errs = 0, checks = 0;
  bit          fin = 0;

  localparam logic [5:0] A_MATCH = 6'h00, A_COUNT = 6'h10, A_STAT = 6'h14,
                         A_IEN = 6'h1C, A_CTRL = 6'h20, A_ACC = 6'h24;

  always #4  clk  = ~clk;   // 125 MHz bus
  always #23 tclk = ~tclk;  // slower timer clock

  xdom_match_timer i_xdom_match_timer (
    .clk_i(clk), .tmr_clk_i(tclk), .rst_ni(rst_n), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle(input logic [31:0] mask, input string tag);
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      bus_rd(A_ACC, v);
      if ((v & mask) == 0) return;
    end
    chk(0, tag, v & mask, 0);
  endtask

  task automatic snapshot(input bit en, output logic [31:0] v);
    bus_wr(A_CTRL, {30'b0, 1'b1, en});
    wait_idle(32'h20, "R3 capture busy stuck");
    bus_rd(A_COUNT, v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(A_MATCH, v); chk(v == 32'hFFFF_FFFF, "R1 match reset", v, 32'hFFFF_FFFF);
    bus_rd(A_COUNT, v); chk(v == 0, "R1 count reset", v, 0);
    bus_rd(A_STAT, v);  chk(v == 0, "R1 status reset", v, 0);
    bus_rd(A_IEN, v);   chk(v == 0, "R1 mask reset", v, 0);
    bus_rd(A_CTRL, v);  chk(v == 0, "R1 control reset", v, 0);
    bus_rd(A_ACC, v);   chk(v == 0, "R1 access reset", v, 0);
    chk(irq == 0, "R1 irq reset", irq, 0);
  endtask

  task automatic t_load_capture;
    logic [31:0] v;
    bus_wr(A_COUNT, 32'h1234_5678);
    bus_rd(A_ACC, v); chk(v[4] == 1, "R4 count busy set", v, 32'h10);
    wait_idle(32'h10, "R4 count busy stuck");
    bus_wr(A_CTRL, 32'h2);
    bus_rd(A_ACC, v); chk(v[5] == 1, "R3 capture busy set", v, 32'h20);
    wait_idle(32'h20, "R3 capture busy stuck");
    bus_rd(A_COUNT, v); chk(v == 32'h1234_5678, "R4 R3 loaded value captured", v, 32'h1234_5678);
    bus_wr(A_CTRL, 32'h3);
    bus_rd(A_CTRL, v); chk(v == 32'h1, "R3 control bit1 reads 0", v, 1);
    wait_idle(32'h20, "R3 capture busy stuck");
    bus_wr(A_CTRL, 32'h0);
  endtask

  task automatic t_running;
    logic [31:0] a, b, c, d;
    snapshot(1, a);
    repeat (100) @(negedge clk);
    snapshot(1, b);
    chk(b > a && (b - a) < 200, "R2 counts while enabled", b, a);
    bus_wr(A_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    snapshot(0, c);
    repeat (100) @(negedge clk);
    snapshot(0, d);
    chk(d == c, "R2 holds while disabled", d, c);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    bus_wr(A_COUNT, 32'hFFFF_FFF0);
    wait_idle(32'h10, "R4 count busy stuck");
    bus_wr(A_CTRL, 32'h1);
    repeat (300) @(negedge clk);
    bus_wr(A_CTRL, 32'h0);
    repeat (30) @(negedge clk);
    snapshot(0, v);
    chk(v < 32'h100, "R2 wraps to zero", v, 32'h0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    bus_wr(A_MATCH, 32'h0000_AAAA);
    bus_wr(A_MATCH, 32'h0000_BBBB);
    bus_rd(A_MATCH, v); chk(v == 32'hAAAA, "R6 match write while busy dropped", v, 32'hAAAA);
    wait_idle(32'h1, "R5 match busy stuck");
    bus_wr(A_COUNT, 32'h500);
    bus_wr(A_COUNT, 32'h600);
    wait_idle(32'h10, "R4 count busy stuck");
    snapshot(0, v);
    chk(v == 32'h500, "R6 count write while busy dropped", v, 32'h500);
  endtask

  task automatic t_match_irq;
    logic [31:0] v;
    bus_wr(A_STAT, 32'hF);
    bus_wr(A_MATCH, 32'h1000);
    bus_rd(A_ACC, v);   chk(v[0] == 1, "R5 match busy set", v, 32'h1);
    bus_rd(A_MATCH, v); chk(v == 32'h1000, "R5 match readback", v, 32'h1000);
    wait_idle(32'h1, "R5 match busy stuck");
    bus_wr(A_COUNT, 32'hFF0);
    wait_idle(32'h10, "R4 count busy stuck");
    bus_rd(A_STAT, v); chk(v == 0, "R7 no event before match", v, 0);
    bus_wr(A_CTRL, 32'h1);
    for (int i = 0; i < 2000; i++) begin
      bus_rd(A_STAT, v);
      if (v[0]) break;
    end
    bus_wr(A_CTRL, 32'h0);
    bus_rd(A_STAT, v); chk(v == 32'h1, "R7 match sets status bit0 only", v, 1);
    chk(irq == 0, "R9 irq masked", irq, 0);
    bus_wr(A_IEN, 32'h2);
    chk(irq == 0, "R9 other mask bit no irq", irq, 0);
    bus_wr(A_IEN, 32'h1);
    chk(irq == 1, "R9 irq enabled", irq, 1);
    bus_wr(A_STAT, 32'hE);
    bus_rd(A_STAT, v); chk(v == 32'h1, "R8 zero bits leave flag", v, 1);
    bus_wr(A_STAT, 32'hF);
    bus_rd(A_STAT, v); chk(v == 0, "R8 write ones clears", v, 0);
    chk(irq == 0, "R9 irq drops after clear", irq, 0);
    bus_wr(A_IEN, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load_capture();
    t_running();
    t_wrap();
    t_busy_ignore();
    t_match_irq();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      errs++; checks++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule